// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Controller

This block lets a clocked design read and write an external static RAM that has no clock: 131,072 words of 8 bits behind a 17-bit address and a shared 8-bit data bus. The client side is a valid/ready request port carrying an address, a write flag and a write byte. Each read returns its byte on a one-cycle response pulse. On the memory side the controller drives the address, a pair of chip enables (one active low, one active high), write enable, output enable, the outgoing data byte, and the enable for the bidirectional data pad. The pad cell sits outside the block.

Every memory timing figure is a parameter counted in clock cycles: the read access window, the turnaround from output enable release to driving the bus, the write pulse width, the hold after the write pulse ends, and the minimum cycle time between accepted requests. At the default values and a 100 MHz clock these give a 60 ns read window, 20 ns of turnaround, a 40 ns write pulse, 60 ns from address valid to the end of the write, and an 80 ns request cycle. When no request is in flight, the memory is held in standby, so its data pins stay at high impedance.

Top module: `sram_ctl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, mem_ce_n=1, mem_ce=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0 and rsp_valid=0. req_ready=1 in the first cycle after release.
- R2: When no request is in progress, the memory is in standby: mem_ce_n=1, mem_ce=0, mem_we_n=1, mem_oe_n=1 and mem_dq_oe=0.
- R3: A read accepted at clock edge 0 (req_valid=1, req_ready=1, req_we=0) selects the memory (mem_ce_n=0, mem_ce=1) with mem_oe_n=0 and mem_we_n=1 in cycles 1 to RD_CYC. mem_addr equals the request address during those cycles.
- R4: In the read's last selected cycle (cycle RD_CYC), mem_dq_in is sampled. In cycle RD_CYC+1, rsp_valid=1 for exactly one cycle and rsp_rdata carries the sampled byte.
- R5: A write accepted at edge 0 selects the memory from cycle 1 with mem_oe_n=1. mem_dq_oe stays 0 for cycles 1 to TURN_CYC and becomes 1 in cycle TURN_CYC+1.
- R6: In a write, mem_we_n=0 in exactly cycles TURN_CYC+1 to TURN_CYC+WE_CYC, and the memory stays selected throughout.
- R7: After mem_we_n returns high, select, address, data and mem_dq_oe are held for HOLD_CYC cycles. In the cycle after that, the memory returns to standby with the drivers off.
- R8: After an acceptance at edge 0, req_ready stays 0 until both the operation has finished and cycle CYCLE_CYC is reached. Only req_valid&&req_ready starts an operation.
- R9: During a write, mem_addr and mem_dq_out equal the request's address and byte and do not change while mem_we_n is low or in the cycle after it rises.
- R10: mem_oe_n is never low in a cycle where mem_dq_oe=1 or mem_we_n=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 17 | Memory address bus |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Enable for the data bus drivers |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
The hardest case to reach from the ports is a request that sits on the port while the controller is still inside the cycle-time window after finishing the previous operation. In that case req_valid is held through cycles where the strobes are already back to standby but req_ready is still low. The stimulus issues requests back to back with req_valid held continuously, so every acceptance lands on the first cycle that R8 allows. It also scrambles the request fields while req_valid is low. A memory model in the bench drives mem_dq_in from the bytes it has observed being written, so each read-back checks the full write and read path.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_PULSE,
    ST_HOLD
  } seq_state_t;
endpackage

// File: rtl/sram_ctl_dcnt.sv
module sram_ctl_dcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC   = 6,
  parameter int TURN_CYC = 2,
  parameter int WE_CYC   = 4,
  parameter int HOLD_CYC = 1,
  parameter int W        = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         start_we,
  input  logic         ph_zero,
  input  logic         gap_zero,
  output logic         ready,
  output logic         ph_load,
  output logic [W-1:0] ph_val,
  output logic         capture,
  output logic         sel,
  output logic         oe,
  output logic         we,
  output logic         dq_en
);
  seq_state_t state_q, state_d;
  logic sel_q, sel_d, oe_q, oe_d, we_q, we_d, dq_en_q, dq_en_d;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    oe_d    = oe_q;
    we_d    = we_q;
    dq_en_d = dq_en_q;
    ph_load = 1'b0;
    ph_val  = '0;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        ph_load = 1'b1;
        sel_d   = 1'b1;
        if (start_we) begin
          state_d = ST_TURN;
          ph_val  = W'(TURN_CYC - 1);
        end else begin
          state_d = ST_READ;
          ph_val  = W'(RD_CYC - 1);
          oe_d    = 1'b1;
        end
      end
      ST_READ: if (ph_zero) begin
        state_d = ST_IDLE;
        capture = 1'b1;
        sel_d   = 1'b0;
        oe_d    = 1'b0;
      end
      ST_TURN: if (ph_zero) begin
        state_d = ST_PULSE;
        ph_load = 1'b1;
        ph_val  = W'(WE_CYC - 1);
        we_d    = 1'b1;
        dq_en_d = 1'b1;
      end
      ST_PULSE: if (ph_zero) begin
        state_d = ST_HOLD;
        ph_load = 1'b1;
        ph_val  = W'(HOLD_CYC - 1);
        we_d    = 1'b0;
      end
      ST_HOLD: if (ph_zero) begin
        state_d = ST_IDLE;
        sel_d   = 1'b0;
        dq_en_d = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      dq_en_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      dq_en_q <= dq_en_d;
    end
  end

  assign ready = (state_q == ST_IDLE) && gap_zero;
  assign sel   = sel_q;
  assign oe    = oe_q;
  assign we    = we_q;
  assign dq_en = dq_en_q;

  assert_we_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (sel_q && !oe_q && dq_en_q));
  assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dq_en_q |-> !oe_q);
  assert_read_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (sel_q && !we_q && !dq_en_q));
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int RD_CYC    = 6,
  parameter int TURN_CYC  = 2,
  parameter int WE_CYC    = 4,
  parameter int HOLD_CYC  = 1,
  parameter int CYCLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int PH_MAX = (RD_CYC > TURN_CYC ? RD_CYC : TURN_CYC) >
                          (WE_CYC > HOLD_CYC ? WE_CYC : HOLD_CYC) ?
                          (RD_CYC > TURN_CYC ? RD_CYC : TURN_CYC) :
                          (WE_CYC > HOLD_CYC ? WE_CYC : HOLD_CYC);
  localparam int PH_W  = $clog2(PH_MAX + 1);
  localparam int GAP_W = $clog2(CYCLE_CYC + 1);

  logic              start, ph_load, ph_zero, gap_zero, capture;
  logic [PH_W-1:0]   ph_val;
  logic              sel, oe, we, dq_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rsp_q;

  assign start = req_valid && req_ready;

  sram_ctl_seq #(
    .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC), .WE_CYC(WE_CYC),
    .HOLD_CYC(HOLD_CYC), .W(PH_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_we(req_we),
    .ph_zero(ph_zero), .gap_zero(gap_zero), .ready(req_ready),
    .ph_load(ph_load), .ph_val(ph_val), .capture(capture),
    .sel(sel), .oe(oe), .we(we), .dq_en(dq_en)
  );

  sram_ctl_dcnt #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  sram_ctl_dcnt #(.W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(start),
    .load_val(GAP_W'(CYCLE_CYC - 1)), .zero(gap_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      if (start)   addr_q  <= req_addr;
      if (start)   wdata_q <= req_wdata;
      if (capture) rdata_q <= mem_dq_in;
      rsp_q <= capture;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_ce_n   = ~sel;
  assign mem_ce     = sel;
  assign mem_oe_n   = ~oe;
  assign mem_we_n   = ~we;
  assign mem_dq_oe  = dq_en;
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;

  assert_ready_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe));
  assert_write_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe && !mem_ce_n));
  assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_turn_before_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_oe_n) && mem_dq_oe));
endmodule

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;
  localparam int RD = 6, TC = 2, WC = 4, HC = 1, CC = 8;
  localparam int WLEN = TC + WC + HC;

  logic clk, rst_n;
  logic req_valid, req_ready, req_we;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic rsp_valid;
  logic [7:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] mem_dq_out, mem_dq_in;

  logic [7:0] mdl [256];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  sram_ctl #(.ADDR_W(17), .DATA_W(8), .RD_CYC(RD), .TURN_CYC(TC), .WE_CYC(WC),
             .HOLD_CYC(HC), .CYCLE_CYC(CC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  assign mem_dq_in = (!mem_ce_n && mem_ce && !mem_oe_n) ? mdl[mem_addr[7:0]] : 8'h00;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: age of the current operation in cycles since acceptance
  bit active = 0, pend = 0, kind = 0, pk = 0;
  int age = 0;
  logic [16:0] ea, pa;
  logic [7:0]  ed, pd;
  bit after_rst = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1", "ce_n", mem_ce_n, 1); chk("R1", "ce", mem_ce, 0);
      chk("R1", "we_n", mem_we_n, 1); chk("R1", "oe_n", mem_oe_n, 1);
      chk("R1", "dq_oe", mem_dq_oe, 0); chk("R1", "rsp_valid", rsp_valid, 0);
      after_rst = 1;
    end else begin
      bit e_sel, e_oe, e_we, e_dq, e_rsp, e_rdy;
      int len;
      if (after_rst) begin
        chk("R1", "ready_after_reset", req_ready, 1);
        chk("R1", "ce_n_after_reset", mem_ce_n, 1);
        after_rst = 0;
      end
      if (pend) begin
        active = 1; age = 1; kind = pk; ea = pa; ed = pd; pend = 0;
      end else if (active) age++;
      len = kind ? WLEN : RD;
      e_sel = active && age >= 1 && age <= len;
      e_oe  = active && !kind && e_sel;
      e_we  = active && kind && age >= TC + 1 && age <= TC + WC;
      e_dq  = active && kind && age >= TC + 1 && age <= WLEN;
      e_rsp = active && !kind && age == RD + 1;
      e_rdy = !active || (age >= len + 1 && age >= CC);
      if (!e_sel) begin
        chk("R2", "standby_ce_n", mem_ce_n, 1); chk("R2", "standby_ce", mem_ce, 0);
        chk("R2", "standby_we_n", mem_we_n, 1); chk("R2", "standby_oe_n", mem_oe_n, 1);
        chk("R2", "standby_dq_oe", mem_dq_oe, 0);
      end else if (!kind) begin
        chk("R3", "read_ce_n", mem_ce_n, 0); chk("R3", "read_ce", mem_ce, 1);
        chk("R3", "read_oe_n", mem_oe_n, 0); chk("R3", "read_we_n", mem_we_n, 1);
        chk("R3", "read_addr", mem_addr, ea);
      end else begin
        chk("R7", "write_ce_n", mem_ce_n, 0); chk("R7", "write_ce", mem_ce, 1);
        chk("R5", "write_oe_n", mem_oe_n, 1);
        chk("R5", "write_dq_oe", mem_dq_oe, e_dq);
        chk("R6", "write_we_n", mem_we_n, !e_we);
        chk("R9", "write_addr", mem_addr, ea);
        if (e_dq) chk("R9", "write_data", mem_dq_out, ed);
        if (e_we && age == TC + 1) mdl[ea[7:0]] = ed;
      end
      chk("R10", "oe_vs_drive", !mem_oe_n && (mem_dq_oe || !mem_we_n), 0);
      chk("R4", "rsp_valid", rsp_valid, e_rsp);
      if (e_rsp) chk("R4", "rsp_rdata", rsp_rdata, mdl[ea[7:0]]);
      chk("R8", "req_ready", req_ready, e_rdy);
      if (req_valid && req_ready) begin
        pend = 1; pk = req_we; pa = req_addr; pd = req_wdata;
      end
    end
  end

  task automatic issue(input logic we, input logic [16:0] a, input logic [7:0] d);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0; req_we = ~we; req_addr = ~a; req_wdata = ~d;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 8'(i) ^ 8'h5A;
    rst_n = 0; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    issue(1, 17'h00000, 8'hA5);
    issue(1, 17'h1FFFF, 8'h3C);
    issue(0, 17'h00000, 8'h00);
    issue(0, 17'h1FFFF, 8'h00);
    issue(0, 17'h00042, 8'h00);
    repeat (5) @(posedge clk); #1;
    issue(1, 17'h0AB17, 8'hFF);
    issue(0, 17'h0AB17, 8'h00);
    repeat (3) @(posedge clk); #1;
    issue(0, 17'h10080, 8'h00);
    issue(1, 17'h10080, 8'h00);
    issue(0, 17'h10080, 8'hEE);
    repeat (20) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule